// File: doc/BRIEF.md
# Command-mode packet front end for a serial display link host

This block sits between a register port and the byte-level transmit path of a display link host running in command mode. Software queues 32-bit payload words and 24-bit packet headers through three register addresses. The block pairs each header with the payload queued ahead of it and emits the packet as a byte stream with a valid/ready handshake. For a long packet it sends the three header bytes and then exactly as many payload bytes as the header's word count. For a short packet it sends only the three header bytes.

When the header names a read request, the block waits after the header for the peripheral's reply. The reply arrives as a byte stream that ends with a last marker. The block packs the reply into 32-bit words and queues them in a read FIFO, which software drains through the payload address. A status word reports the emptiness of all three FIFOs, a read-done flag and a sticky overflow flag. Error codes, turnaround and the physical layer belong to neighbouring blocks.

Top module: `gcmd_pkt_engine`

## Requirements
- R1: A header word holds the data type in bits 5:0, the virtual channel in bits 7:6, a low byte in bits 15:8 and a high byte in bits 23:16. The stream sends {channel, type} first, then the low byte, then the high byte. `tx_last` is high only on the final byte of a packet.
- R2: A data type is long when its low four bits exceed 8. A long packet streams its 3 header bytes plus N payload bytes, where N = {high, low}, so a word count of 0 gives 3 bytes. Every other type streams exactly 3 bytes.
- R3: Payload words are consumed little-endian, with byte 0 in bits 7:0. A packet takes exactly N bytes. The unused byte lanes of its final partial word are thrown away, and the next packet starts on a fresh word. After a packet whose payload was queued in full, the payload FIFO is empty.
- R4: If a long packet's payload is not yet queued when its header is processed, `tx_valid` drops after the header bytes. The stream resumes with the correct bytes once words arrive.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R6: A header with type 0x09 or 0x19 is not queued and produces no bytes. The payload FIFO is left untouched.
- R7: After sending a header with type 0x04, 0x14, 0x24 or 0x06, the block accepts response bytes until `rx_last`. It packs them little-endian into words and zero-fills a final partial word. Each read at address 1 returns the oldest word and removes it. A read at address 1 with the FIFO empty returns 0.
- R8: Address 0 takes headers, address 1 takes payload writes and read-FIFO reads, and address 2 returns status. In the status word, bit 1 is read FIFO empty, bit 3 is payload FIFO empty, bit 5 is command FIFO empty, bit 7 is read done and bit 8 is overflow. After reset the status word reads 0x2A.
- R9: Read done sets on the response byte that carries `rx_last`. It clears on the next write to address 0.
- R10: A write to a full command or payload FIFO, or a response word meeting a full read FIFO, is dropped and sets the overflow bit. The overflow bit stays set until a write to address 2 with bit 8 high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops the read FIFO at address 1) |
| reg_addr | input | 2 | Register address: 0 header, 1 payload, 2 status |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for the current address |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Outgoing byte accepted |
| tx_data | output | 8 | Outgoing packet byte |
| tx_last | output | 1 | Final byte of the packet |
| rx_valid | input | 1 | Response byte valid |
| rx_data | input | 8 | Response byte |
| rx_last | input | 1 | Final response byte |

## Verification
The bench sweeps the word count from 0 to 11. A design that drops or over-reads a partial word shows up as a payload FIFO that is not empty afterwards, or as a misaligned next packet. It walks all 64 data types, which catches a long/short decode that treats a boundary nibble such as 8 or 9 wrongly and so sends two bytes too many or too few. It sends a header ahead of its payload and applies periodic backpressure, so a sequencer that fabricates bytes from an empty FIFO or advances without a handshake emits wrong data. It injects replies of 1 to 9 bytes, overfills the payload FIFO and writes rejected types, which exposes missing zero fill, a read-done flag that fails to set or clear, a lost overflow flag, and null or blanking headers that leak onto the stream.

// File: rtl/gcmd_pkg.sv
package gcmd_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned HDR_W = 24;
   localparam int unsigned ST_W  = 9;

   localparam int unsigned ST_RPL_EMPTY = 1;
   localparam int unsigned ST_WPL_EMPTY = 3;
   localparam int unsigned ST_CMD_EMPTY = 5;
   localparam int unsigned ST_RD_DONE   = 7;
   localparam int unsigned ST_OVF       = 8;

   localparam logic [1:0] A_HDR  = 2'd0;
   localparam logic [1:0] A_PLD  = 2'd1;
   localparam logic [1:0] A_STAT = 2'd2;

   typedef enum logic [1:0] {SQ_IDLE, SQ_HDR, SQ_PLD, SQ_RESP} seq_state_e;

   typedef struct packed {
      logic [7:0] hi;
      logic [7:0] lo;
      logic [1:0] vc;
      logic [5:0] dt;
   } hdr_t;

   function automatic logic dt_is_long(input logic [5:0] dt);
      return dt[3:0] > 4'd8;
   endfunction

   function automatic logic dt_is_read(input logic [5:0] dt);
      return (dt == 6'h04) || (dt == 6'h14) || (dt == 6'h24) || (dt == 6'h06);
   endfunction

   function automatic logic dt_is_filler(input logic [5:0] dt);
      return (dt == 6'h09) || (dt == 6'h19);
   endfunction
endpackage

// File: rtl/gcmd_fifo.sv
module gcmd_fifo #(
   parameter int unsigned W     = 32,
   parameter int unsigned DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned AW = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("gcmd_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wp, rp;

   assign empty = (wp == rp);
   assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
   assign head  = mem[rp[AW-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (push && !full) wp <= wp + 1'b1;
         if (pop && !empty) rp <= rp + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push && !full) mem[wp[AW-1:0]] <= push_data;
   end
endmodule

// File: rtl/gcmd_tx_seq.sv
module gcmd_tx_seq
   import gcmd_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_empty,
   input  logic [HDR_W-1:0]  cmd_head,
   output logic              cmd_pop,
   input  logic              pld_empty,
   input  logic [DATA_W-1:0] pld_head,
   output logic              pld_pop,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [7:0]        tx_data,
   output logic              tx_last,
   output logic              resp_wait,
   input  logic              resp_end
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned BPW = DATA_W / 8;
   localparam int unsigned LW  = $clog2(BPW);

   seq_state_e   st;
   hdr_t         hdr;
   logic [1:0]   hidx;
   logic [15:0]  cnt;
   logic [LW-1:0] lane;
   logic [15:0]  wc;
   logic         lng;
   logic [7:0]   lanes [BPW];

   assign wc  = {hdr.hi, hdr.lo};
   assign lng = dt_is_long(hdr.dt);

   for (genvar g = 0; g < BPW; g++) begin : g_lane
      assign lanes[g] = pld_head[8*g +: 8];
   end

   assign cmd_pop   = (st == SQ_IDLE) && !cmd_empty;
   assign resp_wait = (st == SQ_RESP);

   always_comb begin
      tx_valid = 1'b0;
      tx_data  = '0;
      tx_last  = 1'b0;
      pld_pop  = 1'b0;
      case (st)
         SQ_HDR: begin
            tx_valid = 1'b1;
            case (hidx)
               2'd0:    tx_data = {hdr.vc, hdr.dt};
               2'd1:    tx_data = hdr.lo;
               default: tx_data = hdr.hi;
            endcase
            tx_last = (hidx == 2'd2) && !(lng && wc != 16'd0);
         end
         SQ_PLD: begin
            tx_valid = !pld_empty;
            tx_data  = lanes[lane];
            tx_last  = !pld_empty && (cnt == wc - 16'd1);
            pld_pop  = tx_valid && tx_ready && ((lane == LW'(BPW - 1)) || tx_last);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= SQ_IDLE;
         hdr  <= '0;
         hidx <= '0;
         cnt  <= '0;
         lane <= '0;
      end else begin
         case (st)
            SQ_IDLE: if (!cmd_empty) begin
               hdr  <= hdr_t'(cmd_head);
               hidx <= '0;
               st   <= SQ_HDR;
            end
            SQ_HDR: if (tx_ready) begin
               if (hidx == 2'd2) begin
                  cnt  <= '0;
                  lane <= '0;
                  if (lng && wc != 16'd0)       st <= SQ_PLD;
                  else if (dt_is_read(hdr.dt))  st <= SQ_RESP;
                  else                          st <= SQ_IDLE;
               end else begin
                  hidx <= hidx + 2'd1;
               end
            end
            SQ_PLD: if (tx_valid && tx_ready) begin
               cnt  <= cnt + 16'd1;
               lane <= lane + 1'b1;
               if (tx_last) st <= SQ_IDLE;
            end
            SQ_RESP: if (resp_end) st <= SQ_IDLE;
            default: st <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/gcmd_rx_pack.sv
module gcmd_rx_pack #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              rx_valid,
   input  logic [7:0]        rx_data,
   input  logic              rx_last,
   output logic              push,
   output logic [DATA_W-1:0] push_data,
   output logic              done
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned BPW = DATA_W / 8;
   localparam int unsigned LW  = $clog2(BPW);

   logic [DATA_W-1:0] acc, merged;
   logic [LW-1:0]     k;
   logic              take;

   assign take = en && rx_valid;

   for (genvar g = 0; g < BPW; g++) begin : g_merge
      assign merged[8*g +: 8] = (k == LW'(g)) ? rx_data : acc[8*g +: 8];
   end

   assign push      = take && ((k == LW'(BPW - 1)) || rx_last);
   assign push_data = merged;
   assign done      = take && rx_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
         k   <= '0;
      end else if (take) begin
         if (push) begin
            acc <= '0;
            k   <= '0;
         end else begin
            acc <= merged;
            k   <= k + 1'b1;
         end
      end
   end
endmodule

// File: rtl/gcmd_pkt_engine.sv
module gcmd_pkt_engine
   import gcmd_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned CMD_DEPTH = 4,
   parameter int unsigned WPL_DEPTH = 8,
   parameter int unsigned RPL_DEPTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic              reg_re,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [7:0]        tx_data,
   output logic              tx_last,
   input  logic              rx_valid,
   input  logic [7:0]        rx_data,
   input  logic              rx_last
);
   timeunit 1ns;
   timeprecision 1ps;

   if (DATA_W != 32 && DATA_W != 64) begin : g_bad_width
      $error("gcmd_pkt_engine: DATA_W must be 32 or 64");
   end

   logic              cmd_push, cmd_pop, cmd_empty, cmd_full;
   logic [HDR_W-1:0]  cmd_head;
   logic              wpl_push, wpl_pop, wpl_empty, wpl_full;
   logic [DATA_W-1:0] wpl_head;
   logic              rpl_push, rpl_pop, rpl_empty, rpl_full;
   logic [DATA_W-1:0] rpl_head, rpl_wdata;
   logic              hdr_wr, resp_wait, resp_done;
   logic              ovf, ovf_set, ovf_clr, rd_done;
   logic [ST_W-1:0]   status_w;

   assign hdr_wr   = reg_we && (reg_addr == A_HDR);
   assign cmd_push = hdr_wr && !dt_is_filler(reg_wdata[5:0]);
   assign wpl_push = reg_we && (reg_addr == A_PLD);
   assign rpl_pop  = reg_re && (reg_addr == A_PLD);

   gcmd_fifo #(.W(HDR_W), .DEPTH(CMD_DEPTH)) u_cmd_fifo (
      .clk(clk), .rst_n(rst_n), .push(cmd_push), .push_data(reg_wdata[HDR_W-1:0]),
      .pop(cmd_pop), .head(cmd_head), .empty(cmd_empty), .full(cmd_full));

   gcmd_fifo #(.W(DATA_W), .DEPTH(WPL_DEPTH)) u_wpl_fifo (
      .clk(clk), .rst_n(rst_n), .push(wpl_push), .push_data(reg_wdata),
      .pop(wpl_pop), .head(wpl_head), .empty(wpl_empty), .full(wpl_full));

   gcmd_fifo #(.W(DATA_W), .DEPTH(RPL_DEPTH)) u_rpl_fifo (
      .clk(clk), .rst_n(rst_n), .push(rpl_push), .push_data(rpl_wdata),
      .pop(rpl_pop), .head(rpl_head), .empty(rpl_empty), .full(rpl_full));

   gcmd_tx_seq #(.DATA_W(DATA_W)) u_tx_seq (
      .clk(clk), .rst_n(rst_n),
      .cmd_empty(cmd_empty), .cmd_head(cmd_head), .cmd_pop(cmd_pop),
      .pld_empty(wpl_empty), .pld_head(wpl_head), .pld_pop(wpl_pop),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
      .resp_wait(resp_wait), .resp_end(resp_done));

   gcmd_rx_pack #(.DATA_W(DATA_W)) u_rx_pack (
      .clk(clk), .rst_n(rst_n), .en(resp_wait),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
      .push(rpl_push), .push_data(rpl_wdata), .done(resp_done));

   assign ovf_set = (cmd_push && cmd_full) || (wpl_push && wpl_full) || (rpl_push && rpl_full);
   assign ovf_clr = reg_we && (reg_addr == A_STAT) && reg_wdata[ST_OVF];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf     <= 1'b0;
         rd_done <= 1'b0;
      end else begin
         if (ovf_set)      ovf <= 1'b1;
         else if (ovf_clr) ovf <= 1'b0;
         if (resp_done)    rd_done <= 1'b1;
         else if (hdr_wr)  rd_done <= 1'b0;
      end
   end

   always_comb begin
      status_w               = '0;
      status_w[ST_RPL_EMPTY] = rpl_empty;
      status_w[ST_WPL_EMPTY] = wpl_empty;
      status_w[ST_CMD_EMPTY] = cmd_empty;
      status_w[ST_RD_DONE]   = rd_done;
      status_w[ST_OVF]       = ovf;
   end

   always_comb begin
      case (reg_addr)
         A_PLD:   reg_rdata = rpl_empty ? '0 : rpl_head;
         A_STAT:  reg_rdata = DATA_W'(status_w);
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/gcmd_pkt_engine_chk.sv
module gcmd_pkt_engine_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tx_valid,
   input logic       tx_ready,
   input logic [7:0] tx_data,
   input logic       tx_last,
   input logic       reg_we,
   input logic [1:0] reg_addr,
   input logic [8:0] wdata_lo,
   input logic       rx_valid,
   input logic       rx_last,
   input logic [8:0] status_w
);
   timeunit 1ns;
   timeprecision 1ps;

   AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last |-> tx_valid); // R1

   AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R5

   AST_FILLER_NOT_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == 2'd0 && (wdata_lo[5:0] == 6'h09 || wdata_lo[5:0] == 6'h19)
       && status_w[5]) |=> status_w[5]); // R6

   AST_RD_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == 2'd0 && !(rx_valid && rx_last)) |=> !status_w[7]); // R9

   AST_RD_DONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_w[7]) |-> $past(rx_valid && rx_last)); // R9

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (status_w[8] && !(reg_we && reg_addr == 2'd2 && wdata_lo[8])) |=> status_w[8]); // R10
endmodule

bind gcmd_pkt_engine gcmd_pkt_engine_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
   .tx_data(tx_data), .tx_last(tx_last), .reg_we(reg_we), .reg_addr(reg_addr),
   .wdata_lo(reg_wdata[8:0]), .rx_valid(rx_valid), .rx_last(rx_last),
   .status_w(status_w));

// File: tb/test_gcmd_pkt_engine.sv
module test_gcmd_pkt_engine;
   timeunit 1ns;
   timeprecision 1ps;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0, reg_re = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        tx_valid, tx_last;
   logic        tx_ready = 1'b0;
   logic [7:0]  tx_data;
   logic        rx_valid = 1'b0, rx_last = 1'b0;
   logic [7:0]  rx_data = '0;

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit bp_on = 1'b0;
   logic [7:0] cap_d[$];
   logic       cap_l[$];

   gcmd_pkt_engine i_gcmd_pkt_engine (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .tx_data(tx_data), .tx_last(tx_last), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_last(rx_last));

   always #2 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      tx_ready <= bp_on ? ((cyc % 3) != 0) : 1'b1;
   end

   always @(negedge clk) begin
      if (rst_n && tx_valid && tx_ready) begin
         cap_d.push_back(tx_data);
         cap_l.push_back(tx_last);
      end
   end

   function automatic logic [7:0] pb(input int s, input int i);
      return 8'((s * 37 + i * 11 + 5) & 255);
   endfunction

   function automatic logic [7:0] rb(input int s, input int i);
      return 8'((s * 53 + i * 29 + 1) & 255);
   endfunction

   function automatic logic [31:0] hdr(input logic [5:0] dt, input logic [1:0] vc,
                                       input logic [7:0] lo, input logic [7:0] hi);
      return {8'h00, hi, lo, vc, dt};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_stat(output logic [31:0] v);
      @(negedge clk);
      reg_addr = 2'd2;
      #1 v = reg_rdata;
   endtask

   task automatic pop_rd(output logic [31:0] v);
      @(negedge clk);
      reg_addr = 2'd1; reg_re = 1'b1;
      #1 v = reg_rdata;
      @(negedge clk);
      reg_re = 1'b0;
   endtask

   task automatic push_payload(input int s, input int wc);
      for (int w = 0; w < (wc + 3) / 4; w++) begin
         logic [31:0] word;
         for (int b = 0; b < 4; b++)
            word[8*b +: 8] = (4*w + b < wc) ? pb(s, 4*w + b) : 8'hEE;
         wr(2'd1, word);
      end
   endtask

   task automatic expect_pkt(input string req, input logic [7:0] e[$]);
      int t = 0;
      while (cap_d.size() < e.size() && t < 400) begin
         @(negedge clk);
         t++;
      end
      repeat (4) @(negedge clk);
      chk(cap_d.size() == e.size(), req, "byte count", cap_d.size(), e.size());
      for (int i = 0; i < e.size() && i < cap_d.size(); i++) begin
         chk(cap_d[i] == e[i], req, $sformatf("byte %0d", i), cap_d[i], e[i]);
         chk(cap_l[i] == (i == e.size() - 1), req, $sformatf("last %0d", i),
             cap_l[i], (i == e.size() - 1));
      end
      cap_d.delete();
      cap_l.delete();
   endtask

   task automatic long_pkt(input string req, input logic [5:0] dt, input logic [1:0] vc,
                           input int wc, input int s);
      logic [7:0] e[$];
      push_payload(s, wc);
      wr(2'd0, hdr(dt, vc, 8'(wc), 8'(wc >> 8)));
      e.push_back({vc, dt}); e.push_back(8'(wc)); e.push_back(8'(wc >> 8));
      for (int i = 0; i < wc; i++) e.push_back(pb(s, i));
      expect_pkt(req, e);
   endtask

   task automatic finish_run;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] st, v;
      logic [7:0]  e[$];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      rd_stat(st);
      chk(st == 32'h2A, "R8", "reset status", st, 32'h2A);
      chk(tx_valid == 1'b0, "R8", "reset tx_valid", tx_valid, 0);

      // R1: short writes over all channels
      for (int vc = 0; vc < 4; vc++) begin
         logic [5:0] dts [4] = '{6'h05, 6'h15, 6'h23, 6'h37};
         e.delete();
         wr(2'd0, hdr(dts[vc], 2'(vc), 8'(8'h30 + vc), 8'(8'hA0 + vc)));
         e.push_back({2'(vc), dts[vc]}); e.push_back(8'(8'h30 + vc)); e.push_back(8'(8'hA0 + vc));
         expect_pkt("R1", e);
      end

      // R2 R3: word count sweep, exact consumption
      for (int wc = 0; wc < 12; wc++) begin
         long_pkt("R3", (wc % 2) ? 6'h39 : 6'h29, 2'(wc % 4), wc, wc + 1);
         rd_stat(st);
         chk(st[3] == 1'b1, "R3", "payload fifo empty after packet", st[3], 1);
      end

      // R2: data type sweep
      for (int dt = 0; dt < 64; dt++) begin
         logic lng;
         lng = (dt % 16) > 8;
         if (dt == 6'h09 || dt == 6'h19 || dt == 6'h04 || dt == 6'h14 ||
             dt == 6'h24 || dt == 6'h06) continue;
         e.delete();
         if (lng) wr(2'd1, {16'h0, pb(dt, 1), pb(dt, 0)});
         wr(2'd0, hdr(6'(dt), 2'd1, 8'd2, 8'd0));
         e.push_back({2'd1, 6'(dt)}); e.push_back(8'd2); e.push_back(8'd0);
         if (lng) begin e.push_back(pb(dt, 0)); e.push_back(pb(dt, 1)); end
         expect_pkt("R2", e);
      end

      // R4: header before payload
      wr(2'd0, hdr(6'h29, 2'd2, 8'd6, 8'd0));
      repeat (10) @(negedge clk);
      chk(cap_d.size() == 3, "R4", "bytes before payload", cap_d.size(), 3);
      chk(tx_valid == 1'b0, "R4", "stalled tx_valid", tx_valid, 0);
      push_payload(77, 6);
      e.delete();
      e.push_back({2'd2, 6'h29}); e.push_back(8'd6); e.push_back(8'd0);
      for (int i = 0; i < 6; i++) e.push_back(pb(77, i));
      expect_pkt("R4", e);

      // R5: backpressure
      bp_on = 1'b1;
      long_pkt("R5", 6'h39, 2'd3, 10, 91);
      wr(2'd0, hdr(6'h15, 2'd0, 8'h5A, 8'hC3));
      e.delete(); e.push_back(8'h15); e.push_back(8'h5A); e.push_back(8'hC3);
      expect_pkt("R5", e);
      bp_on = 1'b0;

      // R6: filler types rejected, payload untouched
      wr(2'd1, {pb(5, 3), pb(5, 2), pb(5, 1), pb(5, 0)});
      wr(2'd0, hdr(6'h09, 2'd0, 8'd4, 8'd0));
      wr(2'd0, hdr(6'h19, 2'd1, 8'd4, 8'd0));
      repeat (20) @(negedge clk);
      chk(cap_d.size() == 0, "R6", "bytes from filler types", cap_d.size(), 0);
      rd_stat(st);
      chk(st[5] == 1'b1, "R6", "cmd fifo empty", st[5], 1);
      chk(st[3] == 1'b0, "R6", "payload kept", st[3], 0);
      wr(2'd0, hdr(6'h29, 2'd0, 8'd4, 8'd0));
      e.delete(); e.push_back(8'h29); e.push_back(8'd4); e.push_back(8'd0);
      for (int i = 0; i < 4; i++) e.push_back(pb(5, i));
      expect_pkt("R6", e);

      // R7 R9: read requests with responses of 1..9 bytes
      for (int n = 1; n < 10; n++) begin
         logic [5:0] dt;
         dt = (n % 2) ? 6'h06 : 6'h14;
         wr(2'd0, hdr(dt, 2'd0, 8'(n), 8'd0));
         rd_stat(st);
         chk(st[7] == 1'b0, "R9", "read done cleared by header", st[7], 0);
         e.delete(); e.push_back({2'd0, dt}); e.push_back(8'(n)); e.push_back(8'd0);
         expect_pkt("R7", e);
         for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = rb(n, i); rx_last = (i == n - 1);
         end
         @(negedge clk);
         rx_valid = 1'b0; rx_last = 1'b0;
         rd_stat(st);
         chk(st[7] == 1'b1, "R9", "read done set", st[7], 1);
         chk(st[1] == 1'b0, "R7", "read fifo not empty", st[1], 0);
         for (int w = 0; w < (n + 3) / 4; w++) begin
            logic [31:0] exp;
            for (int b = 0; b < 4; b++)
               exp[8*b +: 8] = (4*w + b < n) ? rb(n, 4*w + b) : 8'h00;
            pop_rd(v);
            chk(v == exp, "R7", $sformatf("read word %0d", w), v, exp);
         end
         rd_stat(st);
         chk(st[1] == 1'b1, "R7", "read fifo drained", st[1], 1);
      end
      pop_rd(v);
      chk(v == 32'h0, "R7", "empty read returns zero", v, 0);

      // R10: payload overflow, sticky, write-one-to-clear
      push_payload(123, 36);
      rd_stat(st);
      chk(st[8] == 1'b1, "R10", "overflow set", st[8], 1);
      wr(2'd2, 32'h0);
      rd_stat(st);
      chk(st[8] == 1'b1, "R10", "overflow holds on zero write", st[8], 1);
      wr(2'd2, 32'h100);
      rd_stat(st);
      chk(st[8] == 1'b0, "R10", "overflow cleared", st[8], 0);
      wr(2'd0, hdr(6'h29, 2'd0, 8'd32, 8'd0));
      e.delete(); e.push_back(8'h29); e.push_back(8'd32); e.push_back(8'd0);
      for (int i = 0; i < 32; i++) e.push_back(pb(123, i));
      expect_pkt("R10", e);
      rd_stat(st);
      chk(st == 32'h2A, "R8", "idle status at end", st, 32'h2A);

      finish_run();
   end
endmodule